// File: doc/BRIEF.md
# Two-Slot Integer/FP Issue Pairing Check

This block holds the issue decision for a two-wide, in-order front end. Each cycle a 64-bit fetch packet brings two decoded instructions in fixed slots: the left (integer) slot and the right (FP) slot. Each slot describes its instruction with an opcode class, one destination specifier and two source specifiers, and each specifier has its own use flag. The block compares these six specifiers with a per-register pending-write scoreboard and with each other. It then raises a go signal for each slot that may leave in this cycle, so zero, one or two instructions issue.

When a slot that holds an instruction cannot leave, the block raises `hold`. The fetch stage must then present the same packet again in the next cycle. The block records that the left slot has already gone, so it never issues twice. The right slot may go in the cycle in which the left slot issues, or in any later cycle of the same packet. When the left slot is empty it may go at once. It pairs with an issuing left slot only if it is an FP instruction that does not depend on the left slot's result. A scoreboard bit is set when a writing instruction issues and cleared by a writeback strobe. Every register in the scoreboard covers both integer and FP registers.

Top module: `dual_pair_issue`

## Requirements
- R1: After a synchronous active-low reset, no scoreboard bit is set and no left-done state is held. The first packet whose specifiers are all free issues both present slots.
- R2: The left slot issues only when the packet is valid, its class is not empty, it has not issued earlier for this packet, and none of its enabled specifiers (src0, src1, dst) names a busy register.
- R3: The right slot never issues while a present left slot is still waiting. It may issue in the same cycle as the left slot, in a later cycle of the same packet, or at once when the left slot is empty.
- R4: Slot class codes are 0 = empty, 1 = integer, 2 = memory, 3 = FP. The left slot may hold any class. The right slot issues in the same cycle as the left only when its class is 3. Otherwise it waits and issues alone in a later cycle.
- R5: When the left slot issues and writes register X, the right slot does not issue in that cycle if any of its enabled specifiers (src0, src1 or dst) is X.
- R6: Issuing an instruction with its destination enabled marks that register busy from the next cycle on. A later instruction that uses that register through any enabled specifier is held.
- R7: A writeback strobe with register index X clears X's busy bit at the next clock edge. The check in the strobe's own cycle still sees X as busy.
- R8: `hold` is high exactly when the packet is valid and some present slot has not issued by the end of this cycle. A slot that issued while `hold` was high does not issue again for the same packet.
- R9: An empty slot (class 0) never issues and never causes `hold` on its own.
- R10: With `pkt_valid` low, neither go signal is raised and `hold` is low, whatever the scoreboard holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | A fetch packet is present |
| int_cls | input | 2 | Left slot class (0 empty, 1 integer, 2 memory, 3 FP) |
| int_dst | input | 6 | Left slot destination register |
| int_dst_en | input | 1 | Left slot writes its destination |
| int_src0 | input | 6 | Left slot first source register |
| int_src0_en | input | 1 | Left slot reads its first source |
| int_src1 | input | 6 | Left slot second source register |
| int_src1_en | input | 1 | Left slot reads its second source |
| fp_cls | input | 2 | Right slot class (same encoding) |
| fp_dst | input | 6 | Right slot destination register |
| fp_dst_en | input | 1 | Right slot writes its destination |
| fp_src0 | input | 6 | Right slot first source register |
| fp_src0_en | input | 1 | Right slot reads its first source |
| fp_src1 | input | 6 | Right slot second source register |
| fp_src1_en | input | 1 | Right slot reads its second source |
| wb_valid | input | 1 | Writeback strobe that clears a busy bit |
| wb_reg | input | 6 | Register index completed by the writeback |
| int_go | output | 1 | Left slot issues this cycle |
| fp_go | output | 1 | Right slot issues this cycle |
| hold | output | 1 | Packet must be presented again next cycle |

## Verification
The bound checker checks on every cycle the rules that are local in time. Both slots going together implies an FP right slot. A right slot that goes never overtakes a present, unissued left slot. A paired right slot never shares the left destination. The left slot never issues twice for one packet. An idle packet produces no output. A go always leaves its destination marked busy, and a writeback frees its register. Only the bench's scenarios can show the sequences that span cycles. These include a packet held over several cycles until a writeback arrives, a writeback that frees a register one cycle late rather than in its own cycle, and a right slot that left behind its partner and issues alone later.

// File: rtl/pair_pkg.sv
// Shared definitions for the two-slot issue pairing check.
// Assumes: a two-bit class field decoded upstream.
package pair_pkg;
    localparam int unsigned CLS_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_EMPTY = 2'd0,
        CLS_INT   = 2'd1,
        CLS_MEM   = 2'd2,
        CLS_FP    = 2'd3
    } slot_cls_e;
endpackage

// File: rtl/pair_scoreboard.sv
// Pending-write scoreboard: one busy bit per architectural register.
// Assumes: at most two sets (one per slot) and one clear per cycle; a set
// takes priority over a clear of the same register.
module pair_scoreboard #(
    parameter int unsigned NREGS = 64,
    localparam int unsigned REG_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_a_en,
    input  logic [REG_W-1:0] set_a_idx,
    input  logic             set_b_en,
    input  logic [REG_W-1:0] set_b_idx,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_idx,
    output logic [NREGS-1:0] busy
);
    logic [NREGS-1:0] busy_nxt;

    // Next-state of the busy vector: clear first, then the issue sets.
    always_comb begin
        busy_nxt = busy;
        if (clr_en)   busy_nxt[clr_idx]   = 1'b0;
        if (set_a_en) busy_nxt[set_a_idx] = 1'b1;
        if (set_b_en) busy_nxt[set_b_idx] = 1'b1;
    end

    // Register the busy vector; reset leaves every register free.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= '0;
        else        busy <= busy_nxt;
    end
endmodule

// File: rtl/pair_sb_lookup.sv
// Looks up the three specifiers of one slot in the scoreboard.
// Assumes: specifiers whose enable is low are ignored.
module pair_sb_lookup #(
    parameter int unsigned NREGS = 64,
    localparam int unsigned REG_W = $clog2(NREGS)
) (
    input  logic [NREGS-1:0] busy,
    input  logic             s0_en,
    input  logic [REG_W-1:0] s0,
    input  logic             s1_en,
    input  logic [REG_W-1:0] s1,
    input  logic             d_en,
    input  logic [REG_W-1:0] d,
    output logic             hit
);
    // Any enabled specifier naming a busy register raises a hit.
    always_comb begin
        hit = (s0_en && busy[s0]) || (s1_en && busy[s1]) || (d_en && busy[d]);
    end
endmodule

// File: rtl/pair_select.sv
// Combinational issue decision for the two fixed slots.
// Assumes: the packet is held stable by fetch while hold is high, and
// left_done says the left slot already issued for this packet.
module pair_select #(
    parameter int unsigned NREGS = 64,
    localparam int unsigned REG_W = $clog2(NREGS)
) (
    input  logic                pkt_valid,
    input  pair_pkg::slot_cls_e l_cls,
    input  pair_pkg::slot_cls_e r_cls,
    input  logic                l_sb_hit,
    input  logic                r_sb_hit,
    input  logic                left_done,
    input  logic                l_wr,
    input  logic [REG_W-1:0]    l_dst,
    input  logic                r_s0_en,
    input  logic [REG_W-1:0]    r_s0,
    input  logic                r_s1_en,
    input  logic [REG_W-1:0]    r_s1,
    input  logic                r_wr,
    input  logic [REG_W-1:0]    r_dst,
    output logic                go_l,
    output logic                go_r,
    output logic                hold
);
    import pair_pkg::*;

    logic l_present, r_present, l_settled, r_settled;
    logic r_dep_on_l, r_pair_block;

    // Left slot: present, not yet gone, and clear of the scoreboard.
    always_comb begin
        l_present = (l_cls != CLS_EMPTY);
        go_l      = pkt_valid && l_present && !left_done && !l_sb_hit;
        l_settled = !l_present || left_done || go_l;
    end

    // Right slot: in order behind left, paired only as an independent FP op.
    always_comb begin
        r_present    = (r_cls != CLS_EMPTY);
        r_dep_on_l   = l_wr && ((r_s0_en && (r_s0 == l_dst)) ||
                                (r_s1_en && (r_s1 == l_dst)) ||
                                (r_wr    && (r_dst == l_dst)));
        r_pair_block = go_l && ((r_cls != CLS_FP) || r_dep_on_l);
        go_r         = pkt_valid && r_present && l_settled &&
                       !r_sb_hit && !r_pair_block;
        r_settled    = !r_present || go_r;
    end

    // Hold the packet while any present slot is still waiting.
    always_comb begin
        hold = pkt_valid && !(l_settled && r_settled);
    end
endmodule

// File: rtl/dual_pair_issue.sv
// Top of the two-slot issue pairing check: scoreboard, per-slot lookups,
// the select logic and the left-done flag that tracks a partly issued packet.
// Assumes: fetch keeps the packet stable while hold is high.
module dual_pair_issue #(
    parameter int unsigned NREGS = 64,
    localparam int unsigned REG_W = $clog2(NREGS),
    localparam int unsigned NSLOT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [1:0]       int_cls,
    input  logic [REG_W-1:0] int_dst,
    input  logic             int_dst_en,
    input  logic [REG_W-1:0] int_src0,
    input  logic             int_src0_en,
    input  logic [REG_W-1:0] int_src1,
    input  logic             int_src1_en,
    input  logic [1:0]       fp_cls,
    input  logic [REG_W-1:0] fp_dst,
    input  logic             fp_dst_en,
    input  logic [REG_W-1:0] fp_src0,
    input  logic             fp_src0_en,
    input  logic [REG_W-1:0] fp_src1,
    input  logic             fp_src1_en,
    input  logic             wb_valid,
    input  logic [REG_W-1:0] wb_reg,
    output logic             int_go,
    output logic             fp_go,
    output logic             hold
);
    import pair_pkg::*;

    logic [NREGS-1:0]            sb_busy;
    logic                        left_done;
    logic [NSLOT-1:0]            sb_hit;
    logic [NSLOT-1:0]            s0_en_v, s1_en_v, d_en_v;
    logic [NSLOT-1:0][REG_W-1:0] s0_v, s1_v, d_v;

    // Gather slot specifiers into arrays indexed 0 = left, 1 = right.
    always_comb begin
        s0_en_v = {fp_src0_en, int_src0_en};
        s1_en_v = {fp_src1_en, int_src1_en};
        d_en_v  = {fp_dst_en,  int_dst_en};
        s0_v    = {fp_src0, int_src0};
        s1_v    = {fp_src1, int_src1};
        d_v     = {fp_dst,  int_dst};
    end

    pair_scoreboard #(.NREGS(NREGS)) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_a_en  (int_go && int_dst_en),
        .set_a_idx (int_dst),
        .set_b_en  (fp_go && fp_dst_en),
        .set_b_idx (fp_dst),
        .clr_en    (wb_valid),
        .clr_idx   (wb_reg),
        .busy      (sb_busy)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_lookup
        pair_sb_lookup #(.NREGS(NREGS)) u_lk (
            .busy  (sb_busy),
            .s0_en (s0_en_v[g]),
            .s0    (s0_v[g]),
            .s1_en (s1_en_v[g]),
            .s1    (s1_v[g]),
            .d_en  (d_en_v[g]),
            .d     (d_v[g]),
            .hit   (sb_hit[g])
        );
    end

    pair_select #(.NREGS(NREGS)) u_sel (
        .pkt_valid (pkt_valid),
        .l_cls     (slot_cls_e'(int_cls)),
        .r_cls     (slot_cls_e'(fp_cls)),
        .l_sb_hit  (sb_hit[0]),
        .r_sb_hit  (sb_hit[1]),
        .left_done (left_done),
        .l_wr      (int_dst_en),
        .l_dst     (int_dst),
        .r_s0_en   (fp_src0_en),
        .r_s0      (fp_src0),
        .r_s1_en   (fp_src1_en),
        .r_s1      (fp_src1),
        .r_wr      (fp_dst_en),
        .r_dst     (fp_dst),
        .go_l      (int_go),
        .go_r      (fp_go),
        .hold      (hold)
    );

    // Remember a left issue while the packet is held; a new packet clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      left_done <= 1'b0;
        else if (!hold)  left_done <= 1'b0;
        else if (int_go) left_done <= 1'b1;
    end
endmodule

// File: rtl/pair_issue_chk.sv
// Assertion checker for dual_pair_issue, attached with bind below.
// Assumes: it sees the top's ports plus the busy vector and left-done flag.
module pair_issue_chk #(
    parameter int unsigned NREGS = 64,
    localparam int unsigned REG_W = $clog2(NREGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic [1:0]       int_cls,
    input logic [REG_W-1:0] int_dst,
    input logic             int_dst_en,
    input logic [REG_W-1:0] int_src0,
    input logic             int_src0_en,
    input logic [REG_W-1:0] int_src1,
    input logic             int_src1_en,
    input logic [1:0]       fp_cls,
    input logic [REG_W-1:0] fp_dst,
    input logic             fp_dst_en,
    input logic [REG_W-1:0] fp_src0,
    input logic             fp_src0_en,
    input logic [REG_W-1:0] fp_src1,
    input logic             fp_src1_en,
    input logic             wb_valid,
    input logic [REG_W-1:0] wb_reg,
    input logic             int_go,
    input logic             fp_go,
    input logic             hold,
    input logic [NREGS-1:0] sb_busy,
    input logic             left_done
);
    // R2
    left_src_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_go |-> !(int_src0_en && sb_busy[int_src0]) && !(int_src1_en && sb_busy[int_src1]));

    // R3
    right_in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_go && int_cls != 2'd0) |-> (int_go || left_done));

    // R4
    pair_fp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_go && fp_go) |-> (fp_cls == 2'd3));

    // R5
    pair_no_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_go && fp_go && int_dst_en) |->
            !(fp_src0_en && fp_src0 == int_dst) && !(fp_src1_en && fp_src1 == int_dst)
            && !(fp_dst_en && fp_dst == int_dst));

    // R6
    issue_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_go && int_dst_en) |=> sb_busy[$past(int_dst)]);

    // R7
    wb_frees_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !(int_go && int_dst_en && int_dst == wb_reg)
                  && !(fp_go && fp_dst_en && fp_dst == wb_reg)) |=> !sb_busy[$past(wb_reg)]);

    // R8
    no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && int_go) |=> !int_go);

    // R9
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_cls == 2'd0) |-> !int_go);

    // R10
    idle_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> (!int_go && !fp_go && !hold));
endmodule

bind dual_pair_issue pair_issue_chk #(.NREGS(NREGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
    .int_cls(int_cls), .int_dst(int_dst), .int_dst_en(int_dst_en),
    .int_src0(int_src0), .int_src0_en(int_src0_en),
    .int_src1(int_src1), .int_src1_en(int_src1_en),
    .fp_cls(fp_cls), .fp_dst(fp_dst), .fp_dst_en(fp_dst_en),
    .fp_src0(fp_src0), .fp_src0_en(fp_src0_en),
    .fp_src1(fp_src1), .fp_src1_en(fp_src1_en),
    .wb_valid(wb_valid), .wb_reg(wb_reg),
    .int_go(int_go), .fp_go(fp_go), .hold(hold),
    .sb_busy(sb_busy), .left_done(left_done)
);

// File: tb/sim_dual_pair_issue.sv
// Bench for dual_pair_issue: a vector table, then directed sequences.
module sim_dual_pair_issue;
    localparam int NREGS = 64;
    localparam int RW    = 6;
    localparam int NV    = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_valid = 1'b0;
    logic [1:0] int_cls = '0, fp_cls = '0;
    logic [RW-1:0] int_dst = '0, int_src0 = '0, int_src1 = '0;
    logic [RW-1:0] fp_dst = '0, fp_src0 = '0, fp_src1 = '0;
    logic int_dst_en = 1'b0, int_src0_en = 1'b0, int_src1_en = 1'b0;
    logic fp_dst_en = 1'b0, fp_src0_en = 1'b0, fp_src1_en = 1'b0;
    logic wb_valid = 1'b0;
    logic [RW-1:0] wb_reg = '0;
    logic int_go, fp_go, hold;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dual_pair_issue #(.NREGS(NREGS)) u0 (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
        .int_cls(int_cls), .int_dst(int_dst), .int_dst_en(int_dst_en),
        .int_src0(int_src0), .int_src0_en(int_src0_en),
        .int_src1(int_src1), .int_src1_en(int_src1_en),
        .fp_cls(fp_cls), .fp_dst(fp_dst), .fp_dst_en(fp_dst_en),
        .fp_src0(fp_src0), .fp_src0_en(fp_src0_en),
        .fp_src1(fp_src1), .fp_src1_en(fp_src1_en),
        .wb_valid(wb_valid), .wb_reg(wb_reg),
        .int_go(int_go), .fp_go(fp_go), .hold(hold)
    );

    typedef struct packed {
        logic [1:0] ic; logic [5:0] id; logic iw; logic [5:0] ia; logic [5:0] ib;
        logic [1:0] fc; logic [5:0] fd; logic fw; logic [5:0] fa; logic [5:0] fb;
        logic [2:0] exp;  // {int_go, fp_go, hold}
    } vec_t;

    // Each vector runs on a freshly reset scoreboard.
    localparam vec_t VT [NV] = '{
        '{2'd1, 6'd1,  1'b1, 6'd2,  6'd3,  2'd3, 6'd33, 1'b1, 6'd34, 6'd35, 3'b110}, // R1 clean pair
        '{2'd2, 6'd4,  1'b1, 6'd5,  6'd6,  2'd3, 6'd40, 1'b1, 6'd41, 6'd42, 3'b110}, // R4 mem+fp
        '{2'd1, 6'd7,  1'b1, 6'd8,  6'd9,  2'd1, 6'd10, 1'b1, 6'd11, 6'd12, 3'b101}, // R4 int right
        '{2'd3, 6'd36, 1'b1, 6'd37, 6'd38, 2'd3, 6'd39, 1'b1, 6'd43, 6'd44, 3'b110}, // R4 fp+fp
        '{2'd1, 6'd10, 1'b1, 6'd11, 6'd12, 2'd3, 6'd46, 1'b1, 6'd10, 6'd47, 3'b101}, // R5 raw src0
        '{2'd2, 6'd45, 1'b1, 6'd1,  6'd2,  2'd3, 6'd45, 1'b1, 6'd48, 6'd49, 3'b101}, // R5 waw
        '{2'd1, 6'd50, 1'b0, 6'd1,  6'd2,  2'd3, 6'd51, 1'b1, 6'd50, 6'd52, 3'b110}, // R5 no write
        '{2'd0, 6'd1,  1'b1, 6'd2,  6'd3,  2'd3, 6'd53, 1'b1, 6'd54, 6'd55, 3'b010}, // R9 left empty
        '{2'd1, 6'd13, 1'b1, 6'd14, 6'd15, 2'd0, 6'd56, 1'b1, 6'd57, 6'd58, 3'b100}, // R9 right empty
        '{2'd0, 6'd1,  1'b1, 6'd2,  6'd3,  2'd0, 6'd4,  1'b1, 6'd5,  6'd6,  3'b000}, // R9 both empty
        '{2'd1, 6'd16, 1'b1, 6'd17, 6'd18, 2'd3, 6'd59, 1'b1, 6'd60, 6'd16, 3'b101}  // R5 raw src1
    };

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic chk3(input string req, input logic [2:0] exp);
        chk(req, "int_go", int_go, exp[2]);
        chk(req, "fp_go",  fp_go,  exp[1]);
        chk(req, "hold",   hold,   exp[0]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pkt_valid = 1'b0; wb_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive(input logic [1:0] ic, input logic [5:0] id, input logic iw,
                         input logic [5:0] ia, input logic [5:0] ib,
                         input logic [1:0] fc, input logic [5:0] fd, input logic fw,
                         input logic [5:0] fa, input logic [5:0] fb);
        pkt_valid = 1'b1;
        int_cls = ic; int_dst = id; int_dst_en = iw;
        int_src0 = ia; int_src0_en = 1'b1; int_src1 = ib; int_src1_en = 1'b1;
        fp_cls = fc; fp_dst = fd; fp_dst_en = fw;
        fp_src0 = fa; fp_src0_en = 1'b1; fp_src1 = fb; fp_src1_en = 1'b1;
    endtask

    // Next cycle: step past one clock edge and settle.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        // R1 / R10: reset state with idle input
        do_reset();
        #1;
        chk3("R10", 3'b000);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            do_reset();
            drive(VT[v].ic, VT[v].id, VT[v].iw, VT[v].ia, VT[v].ib,
                  VT[v].fc, VT[v].fd, VT[v].fw, VT[v].fa, VT[v].fb);
            #1;
            chk3("R4", VT[v].exp);
            if (VT[v].exp[0]) begin
                step();
                chk("R8", "int_go after held issue", int_go, 1'b0);
            end
        end

        // R4: non-FP right slot issues alone the cycle after the left
        do_reset();
        drive(2'd1, 6'd7, 1'b1, 6'd8, 6'd9, 2'd2, 6'd10, 1'b1, 6'd11, 6'd12);
        #1; chk3("R4", 3'b101);
        step(); chk3("R3", 3'b010);

        // R6 / R7: busy register holds a reader until one cycle after writeback
        do_reset();
        drive(2'd1, 6'd20, 1'b1, 6'd1, 6'd2, 2'd0, 6'd0, 1'b0, 6'd0, 6'd0);
        #1; chk3("R1", 3'b100);
        step();
        drive(2'd1, 6'd21, 1'b0, 6'd20, 6'd2, 2'd0, 6'd0, 1'b0, 6'd0, 6'd0);
        #1; chk3("R6", 3'b001);
        step(); chk3("R6", 3'b001);
        wb_valid = 1'b1; wb_reg = 6'd20;
        #1; chk3("R7", 3'b001);
        step();
        wb_valid = 1'b0;
        #1; chk3("R7", 3'b100);

        // R10: idle packet with a busy register
        step();
        drive(2'd1, 6'd22, 1'b1, 6'd1, 6'd2, 2'd0, 6'd0, 1'b0, 6'd0, 6'd0);
        #1; chk3("R2", 3'b100);
        step();
        pkt_valid = 1'b0;
        #1; chk3("R10", 3'b000);

        // R5 / R6 / R3: dependent right waits on scoreboard, then issues alone
        do_reset();
        drive(2'd1, 6'd10, 1'b1, 6'd11, 6'd12, 2'd3, 6'd46, 1'b1, 6'd10, 6'd47);
        #1; chk3("R5", 3'b101);
        step(); chk3("R6", 3'b001);
        wb_valid = 1'b1; wb_reg = 6'd10;
        #1; chk3("R7", 3'b001);
        step();
        wb_valid = 1'b0;
        #1; chk3("R3", 3'b010);

        // R3 / R2: blocked left keeps a clean FP right slot waiting
        do_reset();
        drive(2'd1, 6'd30, 1'b1, 6'd1, 6'd2, 2'd0, 6'd0, 1'b0, 6'd0, 6'd0);
        #1; chk3("R1", 3'b100);
        step();
        drive(2'd1, 6'd31, 1'b1, 6'd30, 6'd2, 2'd3, 6'd33, 1'b1, 6'd34, 6'd35);
        #1; chk3("R3", 3'b001);

        // R2: busy destination also blocks the left slot
        do_reset();
        drive(2'd1, 6'd25, 1'b1, 6'd1, 6'd2, 2'd0, 6'd0, 1'b0, 6'd0, 6'd0);
        step();
        drive(2'd1, 6'd25, 1'b1, 6'd3, 6'd4, 2'd0, 6'd0, 1'b0, 6'd0, 6'd0);
        #1; chk3("R2", 3'b001);

        pkt_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule